// File: doc/BRIEF.md
# 64-bit Shift and Rotate Unit

This block is a purely combinational execution unit for integer shifts and masked rotates. One barrel rotator and one mask generator serve every operation: logical left shift, logical and arithmetic right shift, and rotate-then-mask in three forms (keep from a begin position onward, keep up to an end position, keep a begin-to-end window). Each form runs on either a full 64-bit word or on the low 32-bit word. In a rotate, the bits outside the mask come from a second operand, so the same path also performs rotate-and-insert. A zero insert operand gives a plain clear.

The operation is picked by three control bits. A width flag picks 32- or 64-bit behaviour, and an arithmetic flag picks sign fill for right shifts. A carry-out flags an arithmetic right shift of a negative value that drops a one bit. A sticky-overflow bit and an opaque context word pass through unchanged, so the unit can sit between pipeline registers that belong to the surrounding datapath. The unit has no clock and no state.

Top module: `shrot_unit`

## Requirements
- R1: The operation code is {op_clr_right, op_clr_left, op_right}. 000 is shift left, 001 is shift right, 010 is rotate with clear-left, 100 is rotate with clear-right and 110 is rotate with clear-both. Any code with a clear bit set is a rotate, and op_right is then ignored (011 acts as 010, 111 acts as 110).
- R2: A 64-bit shift left uses shamt_in[6:0] as the count. The result is src_rs shifted left and truncated to 64 bits, so counts from 64 to 127 give zero.
- R3: A 32-bit shift left uses shamt_in[5:0] as the count. result[31:0] is the low 32 bits of src_rs shifted left, so counts from 32 to 63 give zero there. result[63:32] is zero.
- R4: A logical right shift moves src_rs[31:0] right by shamt_in[5:0] when word32 is 1, with result[63:32] zero. When word32 is 0 it moves src_rs right by shamt_in[6:0]. Counts at or above the width give zero.
- R5: A 32-bit arithmetic right shift treats src_rs[31:0] as signed and shifts it by shamt_in[5:0]. Every bit of result[63:32] equals src_rs[31].
- R6: A 64-bit arithmetic right shift treats src_rs as signed and shifts it by shamt_in[6:0], filling with src_rs[63]. Counts of 64 or more give all copies of the sign bit.
- R7: For an arithmetic right shift, carry_out is 1 exactly when the source is negative (bit 31 in 32-bit mode, bit 63 in 64-bit mode) and at least one 1 bit of the source word is shifted out.
- R8: For every operation other than an arithmetic right shift, carry_out is 0.
- R9: Masks use MSB-0 numbering, where position p is result bit 63-p. In 64-bit mode the begin position is {begin_hi, begin_lo} and the end position is end_pos. In 32-bit mode they are 32+begin_lo and 32+end_pos[4:0]. Clear-left keeps begin through 63. Clear-right keeps 0 through end. Clear-both keeps begin through end, and wraps around (begin through 63 plus 0 through end) when begin is greater than end.
- R10: A rotate turns the word left by shamt_in[5:0] in 64-bit mode. In 32-bit mode, src_rs[31:0] is copied into both halves and turned left by shamt_in[4:0].
- R11: In a rotate, each result bit outside the mask is taken from ins_ra. In a shift, ins_ra has no effect on any output.
- R12: so_out equals so_in and ctx_out equals ctx_in for every operation.
- R13: With all inputs zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_rs | input | 64 | Source operand that is shifted or rotated |
| ins_ra | input | 64 | Insert operand, supplying the bits outside the mask in rotates |
| shamt_in | input | 7 | Shift or rotate count |
| begin_lo | input | 5 | Low bits of the mask begin position |
| begin_hi | input | 1 | High bit of the mask begin position (64-bit mode only) |
| end_pos | input | 6 | Mask end position |
| word32 | input | 1 | 1 selects 32-bit operation |
| arith | input | 1 | 1 selects sign fill for right shifts |
| op_right | input | 1 | Operation code bit 0 (right shift) |
| op_clr_left | input | 1 | Operation code bit 1 (clear left of begin) |
| op_clr_right | input | 1 | Operation code bit 2 (clear right of end) |
| so_in | input | 1 | Sticky overflow in |
| ctx_in | input | 16 | Operation context in |
| result | output | 64 | Shift or rotate result |
| carry_out | output | 1 | Carry from an arithmetic right shift |
| so_out | output | 1 | Sticky overflow out |
| ctx_out | output | 16 | Operation context out |

## Verification
Every output is a combinational function of the current inputs. The result, the carry and the two pass-through values are therefore all due in the same cycle the stimulus is applied, with zero register stages between them. The bench drives a new operation just after a rising clock edge and samples every output at the next falling edge, half a period later, when the inputs have been stable long enough. The expected values come from a bench reference model built on plain shift operators and a mask computed bit by bit, with no rotator.

// File: rtl/shrot_pkg.sv
// Shared types for the shift/rotate unit: operation codes and a decode
// helper that sorts a 3-bit code into shift-left, shift-right or rotate.
package shrot_pkg;

    localparam int SHROT_DATA_W = 64;
    localparam int SHROT_CTX_W  = 16;

    // Code bit order is {clear_right, clear_left, right_shift}.
    typedef enum logic [2:0] {
        OPC_SHL    = 3'b000,
        OPC_SHR    = 3'b001,
        OPC_ROT_CL = 3'b010,
        OPC_ROT_CR = 3'b100,
        OPC_ROT_CB = 3'b110
    } shrot_opc_e;

    typedef enum logic [1:0] {
        KIND_SHL = 2'd0,
        KIND_SHR = 2'd1,
        KIND_ROT = 2'd2
    } shrot_kind_e;

    // Any clear bit marks a rotate; otherwise the right-shift bit decides.
    function automatic shrot_kind_e shrot_decode(input logic [2:0] code);
        if (code[2] || code[1])
            return KIND_ROT;
        else if (code[0])
            return KIND_SHR;
        else
            return KIND_SHL;
    endfunction

endpackage

// File: rtl/shrot_rotl.sv
// Left barrel rotator. In half-width mode the low half is copied into
// both halves first, so a rotate by n acts as a rotate of the low word
// by n mod HALF_W. Assumes DATA_W is a power of two.
module shrot_rotl #(
    parameter int DATA_W = shrot_pkg::SHROT_DATA_W,
    localparam int AMT_W  = $clog2(DATA_W),
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] src,
    input  logic              word32,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] rot
);

    logic [DATA_W-1:0] stage [0:AMT_W];

    // Build the stage-0 word: duplicate the low half in 32-bit mode.
    assign stage[0] = word32 ? {src[HALF_W-1:0], src[HALF_W-1:0]} : src;

    // One rotate-by-2^k stage per count bit.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stage[k+1] = amt[k]
            ? {stage[k][DATA_W-1-SH:0], stage[k][DATA_W-1:DATA_W-SH]}
            : stage[k];
    end

    assign rot = stage[AMT_W];

endmodule

// File: rtl/shrot_mask.sv
// Mask generator. For rotates it builds the begin/end window in MSB-0
// numbering (with wrap when begin > end). For shifts it builds the mask
// of bits that survive a shift of the given count, and an empty mask when
// the count reaches the operating width. Assumes DATA_W is a power of two.
module shrot_mask #(
    parameter int DATA_W = shrot_pkg::SHROT_DATA_W,
    localparam int AMT_W  = $clog2(DATA_W),
    localparam int CW     = AMT_W + 1,
    localparam int HALF_W = DATA_W / 2
) (
    input  shrot_pkg::shrot_kind_e kind,
    input  logic                   clr_left,
    input  logic                   clr_right,
    input  logic                   word32,
    input  logic [AMT_W-2:0]       begin_lo,
    input  logic                   begin_hi,
    input  logic [AMT_W-1:0]       end_pos,
    input  logic [CW-1:0]          count,
    output logic [DATA_W-1:0]      mask
);

    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t FULL_C = cnt_t'(DATA_W);
    localparam cnt_t HALF_C = cnt_t'(HALF_W);
    localparam cnt_t LAST_C = cnt_t'(DATA_W - 1);

    // Ones in the k lowest bits (k up to DATA_W).
    function automatic logic [DATA_W-1:0] low_ones(input cnt_t k);
        logic [DATA_W:0] t;
        t = ({{DATA_W{1'b0}}, 1'b1} << k) - 1'b1;
        return t[DATA_W-1:0];
    endfunction

    logic [AMT_W-1:0]  eff_b;
    logic [AMT_W-1:0]  eff_e;
    cnt_t              span;
    logic [DATA_W-1:0] from_b;
    logic [DATA_W-1:0] upto_e;
    logic [DATA_W-1:0] rot_mask;
    logic [DATA_W-1:0] sh_mask;
    logic              out_rng;

    // Effective window ends: 32-bit mode offsets both by the half width.
    always_comb begin
        eff_b = word32 ? {1'b1, begin_lo} : {begin_hi, begin_lo};
        eff_e = word32 ? {1'b1, end_pos[AMT_W-2:0]} : end_pos;
        span  = word32 ? HALF_C : FULL_C;
    end

    // Half-open pieces of the window: MSB-0 begin..last and 0..end.
    always_comb begin
        from_b = low_ones(FULL_C - {1'b0, eff_b});
        upto_e = ~low_ones(LAST_C - {1'b0, eff_e});
    end

    // Rotate mask: pick one side, both, or a wrapped window.
    always_comb begin
        if (clr_left && clr_right)
            rot_mask = (eff_b <= eff_e) ? (from_b & upto_e) : (from_b | upto_e);
        else if (clr_left)
            rot_mask = from_b;
        else
            rot_mask = upto_e;
    end

    // Shift mask: bits that still hold source data after the shift.
    always_comb begin
        out_rng = (count >= span);
        if (out_rng)
            sh_mask = '0;
        else if (kind == shrot_pkg::KIND_SHR)
            sh_mask = low_ones(span - count);
        else
            sh_mask = low_ones(span) & ~low_ones(count);
    end

    // Final mask selection by operation kind.
    assign mask = (kind == shrot_pkg::KIND_ROT) ? rot_mask : sh_mask;

endmodule

// File: rtl/shrot_carry.sv
// Carry generator for arithmetic right shifts: a negative source that
// loses at least one 1 bit. Runs beside the rotator on the raw source, so
// it adds no depth to the data path. Assumes DATA_W is a power of two.
module shrot_carry #(
    parameter int DATA_W = shrot_pkg::SHROT_DATA_W,
    localparam int AMT_W  = $clog2(DATA_W),
    localparam int CW     = AMT_W + 1,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] src,
    input  logic              word32,
    input  logic              arith_shr,
    input  logic [CW-1:0]     count,
    output logic              carry
);

    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t FULL_C = cnt_t'(DATA_W);
    localparam cnt_t HALF_C = cnt_t'(HALF_W);

    // Ones in the k lowest bits (k up to DATA_W).
    function automatic logic [DATA_W-1:0] low_ones(input cnt_t k);
        logic [DATA_W:0] t;
        t = ({{DATA_W{1'b0}}, 1'b1} << k) - 1'b1;
        return t[DATA_W-1:0];
    endfunction

    cnt_t              span;
    cnt_t              lost_n;
    logic              neg;
    logic [DATA_W-1:0] lost;

    // Bits dropped off the low end, capped at the operating width.
    always_comb begin
        span   = word32 ? HALF_C : FULL_C;
        lost_n = (count >= span) ? span : count;
        lost   = low_ones(lost_n);
        neg    = word32 ? src[HALF_W-1] : src[DATA_W-1];
    end

    // Carry only for a negative arithmetic right shift that drops a one.
    assign carry = arith_shr & neg & (|(src & lost));

endmodule

// File: rtl/shrot_unit.sv
// Top of the shift/rotate unit. Decodes the 3-bit code, sends the source
// through one left rotator (right shifts turn left by the negated count),
// merges the rotated word with a fill under the mask, and passes sticky
// overflow and context through. Purely combinational; no clock or reset.
module shrot_unit #(
    parameter int DATA_W = shrot_pkg::SHROT_DATA_W,
    parameter int CTX_W  = shrot_pkg::SHROT_CTX_W,
    localparam int AMT_W  = $clog2(DATA_W),
    localparam int CW     = AMT_W + 1,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] src_rs,
    input  logic [DATA_W-1:0] ins_ra,
    input  logic [CW-1:0]     shamt_in,
    input  logic [AMT_W-2:0]  begin_lo,
    input  logic              begin_hi,
    input  logic [AMT_W-1:0]  end_pos,
    input  logic              word32,
    input  logic              arith,
    input  logic              op_right,
    input  logic              op_clr_left,
    input  logic              op_clr_right,
    input  logic              so_in,
    input  logic [CTX_W-1:0]  ctx_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              so_out,
    output logic [CTX_W-1:0]  ctx_out
);

    import shrot_pkg::*;

    shrot_kind_e       kind;
    logic [CW-1:0]     count;
    logic [AMT_W-1:0]  rot_amt;
    logic [DATA_W-1:0] rot;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] fill;
    logic              sign_bit;
    logic              arith_shr;

    // Operation kind from the code {clear_right, clear_left, right_shift}.
    assign kind = shrot_decode({op_clr_right, op_clr_left, op_right});

    // Shift count: 6 bits in 32-bit mode, 7 bits in 64-bit mode.
    assign count = word32 ? {1'b0, shamt_in[AMT_W-1:0]} : shamt_in;

    // Rotate amount: right shifts turn left by the negated count.
    assign rot_amt = (kind == KIND_SHR) ? (~count[AMT_W-1:0] + 1'b1)
                                        : count[AMT_W-1:0];

    shrot_rotl #(.DATA_W(DATA_W)) u_rotl (
        .src    (src_rs),
        .word32 (word32),
        .amt    (rot_amt),
        .rot    (rot)
    );

    shrot_mask #(.DATA_W(DATA_W)) u_mask (
        .kind      (kind),
        .clr_left  (op_clr_left),
        .clr_right (op_clr_right),
        .word32    (word32),
        .begin_lo  (begin_lo),
        .begin_hi  (begin_hi),
        .end_pos   (end_pos),
        .count     (count),
        .mask      (mask)
    );

    // Arithmetic right shift flag and the sign bit of the active word.
    always_comb begin
        arith_shr = (kind == KIND_SHR) && arith;
        sign_bit  = word32 ? src_rs[HALF_W-1] : src_rs[DATA_W-1];
    end

    shrot_carry #(.DATA_W(DATA_W)) u_carry (
        .src       (src_rs),
        .word32    (word32),
        .arith_shr (arith_shr),
        .count     (count),
        .carry     (carry_out)
    );

    // Fill for bits outside the mask: insert operand, sign, or zero.
    always_comb begin
        if (kind == KIND_ROT)
            fill = ins_ra;
        else if (arith_shr && sign_bit)
            fill = '1;
        else
            fill = '0;
    end

    // Merge rotated data under the mask with the fill elsewhere.
    assign result = (rot & mask) | (fill & ~mask);

    // Pass-through of sticky overflow and context.
    assign so_out  = so_in;
    assign ctx_out = ctx_in;

endmodule

// File: rtl/shrot_unit_chk.sv
// Checker for shrot_unit: immediate assertions on the output ports that
// follow from the requirements. Bound to every shrot_unit instance.
module shrot_unit_chk #(
    parameter int DATA_W = shrot_pkg::SHROT_DATA_W,
    localparam int AMT_W  = $clog2(DATA_W),
    localparam int CW     = AMT_W + 1,
    localparam int HALF_W = DATA_W / 2
) (
    input logic [DATA_W-1:0] src_rs,
    input logic [CW-1:0]     shamt_in,
    input logic              word32,
    input logic              arith,
    input logic              op_right,
    input logic              op_clr_left,
    input logic              op_clr_right,
    input logic [DATA_W-1:0] result,
    input logic              carry_out
);

    logic [2:0] code;
    logic       is_shr_ar;

    assign code      = {op_clr_right, op_clr_left, op_right};
    assign is_shr_ar = (code == 3'b001) && arith;

    // Output-level checks on settled combinational values.
    always_comb begin
        if (word32 && code == 3'b000)
            assert_upper_zero_shl_R3: assert (result[DATA_W-1:HALF_W] == '0)
                else $error("upper half not zero after 32-bit left shift");
        if (word32 && code == 3'b001 && !arith)
            assert_upper_zero_shr_R4: assert (result[DATA_W-1:HALF_W] == '0)
                else $error("upper half not zero after 32-bit logical right shift");
        if (word32 && is_shr_ar)
            assert_upper_sign_R5: assert (result[DATA_W-1:HALF_W] == {HALF_W{src_rs[HALF_W-1]}})
                else $error("upper half not sign copies after 32-bit arithmetic shift");
        if (!word32 && code == 3'b000 && shamt_in[CW-1])
            assert_wide_shl_zero_R2: assert (result == '0)
                else $error("64-bit left shift by 64 or more not zero");
        if (carry_out)
            assert_carry_neg_R7: assert (word32 ? src_rs[HALF_W-1] : src_rs[DATA_W-1])
                else $error("carry set for non-negative source");
        if (!is_shr_ar)
            assert_carry_clear_R8: assert (!carry_out)
                else $error("carry set outside arithmetic right shift");
    end

endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .src_rs       (src_rs),
    .shamt_in     (shamt_in),
    .word32       (word32),
    .arith        (arith),
    .op_right     (op_right),
    .op_clr_left  (op_clr_left),
    .op_clr_right (op_clr_right),
    .result       (result),
    .carry_out    (carry_out)
);

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
// Bench for shrot_unit: directed corner cases plus seeded random
// operations, compared against a reference model built on plain shifts.
module shrot_unit_tb;

    localparam real CLK_HALF = 2.5;
    localparam int  WD_CYCLES = 200000;

    logic clk = 1'b0;
    always #(CLK_HALF) clk = ~clk;

    logic [63:0] src_rs = '0;
    logic [63:0] ins_ra = '0;
    logic [6:0]  shamt_in = '0;
    logic [4:0]  begin_lo = '0;
    logic        begin_hi = 1'b0;
    logic [5:0]  end_pos = '0;
    logic        word32 = 1'b0;
    logic        arith = 1'b0;
    logic        op_right = 1'b0;
    logic        op_clr_left = 1'b0;
    logic        op_clr_right = 1'b0;
    logic        so_in = 1'b0;
    logic [15:0] ctx_in = '0;
    logic [63:0] result;
    logic        carry_out;
    logic        so_out;
    logic [15:0] ctx_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    shrot_unit u_dut (
        .src_rs(src_rs), .ins_ra(ins_ra), .shamt_in(shamt_in),
        .begin_lo(begin_lo), .begin_hi(begin_hi), .end_pos(end_pos),
        .word32(word32), .arith(arith), .op_right(op_right),
        .op_clr_left(op_clr_left), .op_clr_right(op_clr_right),
        .so_in(so_in), .ctx_in(ctx_in), .result(result),
        .carry_out(carry_out), .so_out(so_out), .ctx_out(ctx_out)
    );

    // Reference model, written from the requirements.
    function automatic void ref_eval(
        input  logic [63:0] rs, ra, input logic [6:0] sh,
        input  logic [4:0] blo, input logic bhi, input logic [5:0] e,
        input  logic w32, ar, rsf, cl, cr,
        output logic [63:0] res, output logic cy);
        logic [63:0] x, rot, m;
        logic signed [63:0] sv;
        logic signed [31:0] sv32;
        logic [31:0] r32;
        int s, n, b, ee;
        cy = 1'b0;
        if (cl || cr) begin
            s   = w32 ? int'(sh[4:0]) : int'(sh[5:0]);
            x   = w32 ? {rs[31:0], rs[31:0]} : rs;
            rot = (s == 0) ? x : ((x << s) | (x >> (64 - s)));
            b   = w32 ? 32 + int'(blo) : int'({bhi, blo});
            ee  = w32 ? 32 + int'(e[4:0]) : int'(e);
            for (int p = 0; p < 64; p++) begin
                bit in;
                if (cl && cr) in = (b <= ee) ? (p >= b && p <= ee) : (p >= b || p <= ee);
                else if (cl)  in = (p >= b);
                else          in = (p <= ee);
                m[63-p] = in;
            end
            res = (rot & m) | (ra & ~m);
        end else if (!rsf) begin
            if (w32) begin
                n = int'(sh[5:0]);
                x = rs << n;
                res = {32'h0, x[31:0]};
            end else begin
                n = int'(sh);
                res = (n >= 64) ? 64'h0 : (rs << n);
            end
        end else if (w32) begin
            n = int'(sh[5:0]);
            if (ar) begin
                sv32 = rs[31:0];
                r32 = (n >= 32) ? {32{rs[31]}} : 32'(sv32 >>> n);
                res = {{32{rs[31]}}, r32};
                cy = rs[31] && ((rs[31:0] & ((n >= 32) ? 32'hFFFF_FFFF : 32'((64'h1 << n) - 1))) != 0);
            end else begin
                r32 = (n >= 32) ? 32'h0 : (rs[31:0] >> n);
                res = {32'h0, r32};
            end
        end else begin
            n = int'(sh);
            if (ar) begin
                sv = rs;
                res = (n >= 64) ? {64{rs[63]}} : 64'(sv >>> n);
                cy = rs[63] && ((rs & ((n >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'h1 << n) - 1))) != 0);
            end else begin
                res = (n >= 64) ? 64'h0 : (rs >> n);
            end
        end
    endfunction

    // Requirement tag for the result of a given operation.
    function automatic string res_tag(input logic w32, ar, rsf, cl, cr);
        if (cl || cr) return "R9";
        if (!rsf)     return w32 ? "R3" : "R2";
        if (!ar)      return "R4";
        return w32 ? "R5" : "R6";
    endfunction

    task automatic check(input string tag, input logic [63:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one operation after a rising edge, compare at the falling edge.
    task automatic run_case(
        input string rtag,
        input logic [63:0] rs, ra, input logic [6:0] sh,
        input logic [4:0] blo, input logic bhi, input logic [5:0] e,
        input logic w32, ar, rsf, cl, cr, input logic so, input logic [15:0] ctx);
        logic [63:0] exp_res;
        logic exp_cy;
        @(posedge clk);
        src_rs = rs; ins_ra = ra; shamt_in = sh; begin_lo = blo; begin_hi = bhi;
        end_pos = e; word32 = w32; arith = ar; op_right = rsf;
        op_clr_left = cl; op_clr_right = cr; so_in = so; ctx_in = ctx;
        @(negedge clk);
        ref_eval(rs, ra, sh, blo, bhi, e, w32, ar, rsf, cl, cr, exp_res, exp_cy);
        check((rtag == "") ? res_tag(w32, ar, rsf, cl, cr) : rtag, result, exp_res);
        check((!(cl || cr) && rsf && ar) ? "R7" : "R8", {63'h0, carry_out}, {63'h0, exp_cy});
        check("R12", {63'h0, so_out}, {63'h0, so});
        check("R12", {48'h0, ctx_out}, {48'h0, ctx});
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(2.0 * CLK_HALF * WD_CYCLES);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        // R13: idle state with all inputs zero.
        @(negedge clk);
        check("R13", result, 64'h0);
        check("R13", {63'h0, carry_out}, 64'h0);
        check("R13", {47'h0, so_out, ctx_out}, 64'h0);

        // R2: 64-bit left shift edges.
        run_case("R2", 64'h8000_0000_0000_0001, '0, 7'd63, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h1234);
        run_case("R2", 64'hFFFF_FFFF_FFFF_FFFF, '0, 7'd64, 0, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0001);
        // R3: 32-bit left shift edges.
        run_case("R3", 64'hDEAD_BEEF_8000_0001, '0, 7'd31, 0, 0, 0, 1, 0, 0, 0, 0, 0, 16'h0);
        run_case("R3", 64'hFFFF_FFFF_FFFF_FFFF, '0, 7'd32, 0, 0, 0, 1, 0, 0, 0, 0, 0, 16'h0);
        // R4: logical right shifts.
        run_case("R4", 64'hFFFF_FFFF_8000_0000, '0, 7'd31, 0, 0, 0, 1, 0, 1, 0, 0, 0, 16'h0);
        run_case("R4", 64'h8000_0000_0000_0000, '0, 7'd100, 0, 0, 0, 0, 0, 1, 0, 0, 0, 16'h0);
        // R5 / R6 / R7: arithmetic right shifts and carry.
        run_case("R5", 64'h0000_0000_8000_0003, '0, 7'd1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 16'h0);
        run_case("R5", 64'h1234_5678_8000_0000, '0, 7'd40, 0, 0, 0, 1, 1, 1, 0, 0, 0, 16'h0);
        run_case("R6", 64'h8000_0000_0000_0000, '0, 7'd127, 0, 0, 0, 0, 1, 1, 0, 0, 0, 16'h0);
        run_case("R7", 64'hF000_0000_0000_0100, '0, 7'd8, 0, 0, 0, 0, 1, 1, 0, 0, 0, 16'h0);
        run_case("R7", 64'h7000_0000_0000_00FF, '0, 7'd8, 0, 0, 0, 0, 1, 1, 0, 0, 0, 16'h0);
        // R9: masks, including a wrapped window and the 32-bit offset.
        run_case("R9", 64'hFFFF_FFFF_FFFF_FFFF, '0, 7'd0, 5'd20, 0, 6'd6, 1, 0, 0, 1, 1, 0, 16'h0);
        run_case("R9", 64'hFFFF_FFFF_FFFF_FFFF, '0, 7'd0, 5'd4, 1, 6'd10, 0, 0, 0, 1, 1, 0, 16'h0);
        run_case("R9", 64'hFFFF_FFFF_FFFF_FFFF, '0, 7'd0, 5'd3, 1, 6'd0, 0, 0, 0, 1, 0, 0, 16'h0);
        run_case("R9", 64'hFFFF_FFFF_FFFF_FFFF, '0, 7'd0, 5'd0, 0, 6'd20, 0, 0, 0, 0, 1, 0, 16'h0);
        // R10: full-window rotates show the bare rotation.
        run_case("R10", 64'h0123_4567_89AB_CDEF, '0, 7'd12, 5'd0, 0, 6'd63, 0, 0, 0, 1, 0, 0, 16'h0);
        run_case("R10", 64'hFFFF_0000_DEAD_BEEF, '0, 7'd37, 5'd0, 0, 6'd31, 1, 0, 0, 1, 1, 0, 16'h0);
        // R11: insert under the mask, and insert operand ignored by a shift.
        run_case("R11", 64'hDEAD_BEEF, 64'h1234_5678, 7'd5, 5'd20, 0, 6'd6, 1, 0, 0, 1, 1, 0, 16'h0);
        run_case("R11", 64'h00FF_00FF_00FF_00FF, 64'hFFFF_FFFF_FFFF_FFFF, 7'd4, 0, 0, 0, 0, 0, 1, 0, 0, 0, 16'h0);
        // R1: codes 011 and 111 act as rotates with the right-shift bit ignored.
        run_case("R1", 64'h0123_4567_89AB_CDEF, 64'hAAAA, 7'd8, 5'd8, 0, 6'd0, 0, 1, 1, 1, 0, 0, 16'h0);
        run_case("R1", 64'h0123_4567_89AB_CDEF, 64'h5555, 7'd3, 5'd2, 1, 6'd40, 0, 0, 1, 1, 1, 1, 16'hBEEF);

        // Seeded random operations across all codes and widths.
        for (int i = 0; i < 600; i++) begin
            logic [2:0] code;
            logic [6:0] sh;
            code = 3'($urandom_range(0, 7));
            sh = ($urandom_range(0, 3) == 0) ? 7'($urandom_range(28, 70)) : 7'($urandom);
            run_case("", {$urandom, $urandom}, {$urandom, $urandom}, sh,
                     5'($urandom), 1'($urandom), 6'($urandom), 1'($urandom),
                     1'($urandom), code[0], code[1], code[2], 1'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule